// File: doc/BRIEF.md
# Dual-Role Controller Register File

This block is the 32-bit register slave of a controller that acts either as a bus host or as a bus device, never both at once. A simple valid/ready request port reaches four register groups: global, host, device and power/clock-gating. The host and device groups share the address space. Only the group that matches the current role, given by an input pin, may be used. Touching the other role's group completes on the bus but has no effect on any register, returns zero, and raises a mode-mismatch interrupt.

The global group holds four registers. The first carries a self-clearing soft-reset bit that drives a reset pulse into the rest of the controller. The second holds the write-1-to-clear interrupt status. The third holds the interrupt mask. The fourth holds the attributes of the controller's bus master: cacheable, bufferable and privileged. The attribute register accepts a write only while the master reports that it is idle. A write at any other time is dropped and sets a sticky error flag.

Top module: `drc_csr`

## Requirements
- R1: An access is accepted on a clock edge where req_valid and req_ready are both high. In the next cycle rsp_valid is high for one cycle. For a read, rsp_rdata then carries the 32-bit register value; for a write, rsp_rdata is zero.
- R2: req_addr[11:10] selects the group: 00 global, 01 host, 10 device, 11 power. req_addr[9:2] is the word offset within the group, and req_addr[1:0] is ignored. The host, device and power groups each hold N_GRP_REGS (default 2) read/write 32-bit words at offsets 0 and up.
- R3: The global word offsets are fixed. Offset 0 is CTRL, with the soft-reset bit in bit 0. Offset 1 is INT_STAT, with mismatch in bit 0 and attribute error in bit 1. Offset 2 is INT_MASK, with the same bit layout as INT_STAT. Offset 3 is MST_ATTR, with cacheable in bit 0, bufferable in bit 1 and privileged in bit 2.
- R4: Any access to the device group while role_host=1, or to the host group while role_host=0, sets INT_STAT bit 0. Such a write changes no register, and such a read returns zero.
- R5: A write to an unimplemented offset changes no register, and a read from one returns zero.
- R6: Writing 1 to an INT_STAT bit clears that bit. irq is high whenever some INT_STAT bit is set and the INT_MASK bit at the same position is also set.
- R7: A write to MST_ATTR while master_idle=1 drives bits [2:0] onto mst_attr from the next cycle.
- R8: A write to MST_ATTR while master_idle=0 leaves mst_attr unchanged and sets INT_STAT bit 1. That bit stays set until it is cleared by software.
- R9: Writing 1 to CTRL bit 0 raises core_rst for exactly 8 cycles, starting the cycle after the write is accepted. req_ready is low during the pulse. Afterwards, CTRL bit 0 reads 0.
- R10: The soft-reset pulse clears INT_STAT and all host, device and power registers. It leaves INT_MASK and MST_ATTR unchanged.
- R11: After rst_n is released, every register is zero, irq, core_rst and mst_attr are 0, and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept an access (low during soft reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| role_host | input | 1 | Current role: 1 = host, 0 = device |
| master_idle | input | 1 | Bus master reports no transfer in flight |
| irq | output | 1 | Masked interrupt |
| core_rst | output | 1 | Soft-reset pulse to the controller core |
| mst_attr | output | 3 | Bus master attributes {privileged, bufferable, cacheable} |

## Verification
A corrupted role decode shows up on the same response that the wrong access produces. It appears one cycle after acceptance, either as nonzero read data where zero was due or as irq rising on an access that should have been clean. A wrong soft-reset counter shows directly as a core_rst pulse of the wrong length, visible on req_ready too. A faulty attribute guard shows on mst_attr one cycle after a write made while the master was busy. Cleared or surviving register state only becomes visible on the next read of that register, so the bench reads every group back after each disturbing event.

// File: rtl/drc_csr.sv
module drc_csr #(
  parameter int ADDR_W      = 12,
  parameter int N_GRP_REGS  = 2,
  parameter int SRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              role_host,
  input  logic              master_idle,
  output logic              irq,
  output logic              core_rst,
  output logic [2:0]        mst_attr
);
  localparam int DATA_W = 32;
  localparam int OFF_W  = ADDR_W - 4;
  localparam int IDX_W  = (N_GRP_REGS > 1) ? $clog2(N_GRP_REGS) : 1;
  localparam int CNT_W  = $clog2(SRST_CYCLES + 1);
  localparam logic [1:0] G_GLB = 2'b00, G_HST = 2'b01, G_DEV = 2'b10, G_PWR = 2'b11;

  logic [DATA_W-1:0] host_r [N_GRP_REGS];
  logic [DATA_W-1:0] dev_r  [N_GRP_REGS];
  logic [DATA_W-1:0] pwr_r  [N_GRP_REGS];
  logic [1:0]        int_stat, int_mask;
  logic [CNT_W-1:0]  srst_cnt;
  logic [DATA_W-1:0] rd_val;

  wire             acc   = req_valid & req_ready;
  wire [1:0]       grp   = req_addr[ADDR_W-1 -: 2];
  wire [OFF_W-1:0] off   = req_addr[ADDR_W-3:2];
  wire [IDX_W-1:0] idx   = off[IDX_W-1:0];
  wire             in_rg = off < OFF_W'(N_GRP_REGS);
  wire             mism  = (grp == G_HST && !role_host) || (grp == G_DEV && role_host);
  wire             unused_ok = ^req_addr[1:0];

  assign core_rst  = (srst_cnt != '0);
  assign req_ready = ~core_rst;
  assign irq       = |(int_stat & int_mask);

  always_comb begin
    rd_val = '0;
    case (grp)
      G_GLB: case (off)
        OFF_W'(0): rd_val[0]   = core_rst;
        OFF_W'(1): rd_val[1:0] = int_stat;
        OFF_W'(2): rd_val[1:0] = int_mask;
        OFF_W'(3): rd_val[2:0] = mst_attr;
        default:   rd_val = '0;
      endcase
      G_HST: if (role_host && in_rg)  rd_val = host_r[idx];
      G_DEV: if (!role_host && in_rg) rd_val = dev_r[idx];
      default: if (in_rg) rd_val = pwr_r[idx];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_GRP_REGS; i++) begin
        host_r[i] <= '0;
        dev_r[i]  <= '0;
        pwr_r[i]  <= '0;
      end
      int_stat  <= '0;
      int_mask  <= '0;
      mst_attr  <= '0;
      srst_cnt  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= (acc && !req_write) ? rd_val : '0;
      if (core_rst) begin
        srst_cnt <= srst_cnt - 1'b1;
        int_stat <= '0;
        for (int i = 0; i < N_GRP_REGS; i++) begin
          host_r[i] <= '0;
          dev_r[i]  <= '0;
          pwr_r[i]  <= '0;
        end
      end else if (acc) begin
        if (mism) int_stat[0] <= 1'b1;
        if (req_write) begin
          case (grp)
            G_GLB: case (off)
              OFF_W'(0): if (req_wdata[0]) srst_cnt <= CNT_W'(SRST_CYCLES);
              OFF_W'(1): int_stat <= int_stat & ~req_wdata[1:0];
              OFF_W'(2): int_mask <= req_wdata[1:0];
              OFF_W'(3): begin
                if (master_idle) mst_attr <= req_wdata[2:0];
                else             int_stat[1] <= 1'b1;
              end
              default: ;
            endcase
            G_HST: if (role_host && in_rg)  host_r[idx] <= req_wdata;
            G_DEV: if (!role_host && in_rg) dev_r[idx]  <= req_wdata;
            default: if (in_rg) pwr_r[idx] <= req_wdata;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/drc_csr_chk.sv
module drc_csr_chk #(
  parameter int ADDR_W      = 12,
  parameter int SRST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              role_host,
  input logic              master_idle,
  input logic              core_rst,
  input logic [2:0]        mst_attr,
  input logic [1:0]        int_stat
);
  logic [15:0] run;
  wire acc     = req_valid && req_ready;
  wire bad_grp = (req_addr[ADDR_W-1 -: 2] == 2'b01 && !role_host) ||
                 (req_addr[ADDR_W-1 -: 2] == 2'b10 && role_host);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else        run <= core_rst ? run + 1'b1 : '0;

  // R1
  rsp_follows_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R4
  mism_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_grp) |=> int_stat[0]);

  // R4
  mism_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bad_grp && !req_write) |=> (rsp_rdata == 32'd0));

  // R8
  attr_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mst_attr) |-> $past(master_idle));

  // R9
  srst_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (run < 16'(SRST_CYCLES)));

  // R9
  srst_full_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (run == 16'(SRST_CYCLES)));

  // R9
  srst_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !req_ready);

  // R10
  srst_clears_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (int_stat == 2'b00));
endmodule

bind drc_csr drc_csr_chk #(.ADDR_W(ADDR_W), .SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .role_host(role_host), .master_idle(master_idle),
  .core_rst(core_rst), .mst_attr(mst_attr), .int_stat(int_stat)
);

// File: tb/drc_csr_tb.sv
module drc_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        role_host = 1'b1, master_idle = 1'b1;
  logic        req_ready, rsp_valid, irq, core_rst;
  logic [31:0] rsp_rdata;
  logic [2:0]  mst_attr;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  drc_csr u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .role_host(role_host),
    .master_idle(master_idle), .irq(irq), .core_rst(core_rst), .mst_attr(mst_attr)
  );

  // {wr, host, idle, addr, wdata, exp_rdata, exp_irq}
  localparam int NV = 24;
  localparam logic [79:0] VEC [NV] = '{
    {1'b1,1'b1,1'b1,12'h008,32'h3,       32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'h008,32'h0,       32'h3,       1'b0},
    {1'b1,1'b1,1'b1,12'h400,32'hA5A50001,32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'h400,32'h0,       32'hA5A50001,1'b0},
    {1'b1,1'b1,1'b1,12'h800,32'h1234,    32'h0,       1'b1},
    {1'b1,1'b1,1'b1,12'h004,32'h1,       32'h0,       1'b0},
    {1'b0,1'b0,1'b1,12'h800,32'h0,       32'h0,       1'b0},
    {1'b1,1'b0,1'b1,12'h800,32'h5678,    32'h0,       1'b0},
    {1'b0,1'b0,1'b1,12'h800,32'h0,       32'h5678,    1'b0},
    {1'b0,1'b0,1'b1,12'h400,32'h0,       32'h0,       1'b1},
    {1'b0,1'b0,1'b1,12'h004,32'h0,       32'h1,       1'b1},
    {1'b1,1'b0,1'b1,12'h004,32'h1,       32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'h400,32'h0,       32'hA5A50001,1'b0},
    {1'b1,1'b1,1'b1,12'h0F0,32'hFFFFFFFF,32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'h0F0,32'h0,       32'h0,       1'b0},
    {1'b1,1'b1,1'b1,12'h00C,32'h5,       32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'h00C,32'h0,       32'h5,       1'b0},
    {1'b1,1'b1,1'b0,12'h00C,32'h2,       32'h0,       1'b1},
    {1'b0,1'b1,1'b1,12'h00C,32'h0,       32'h5,       1'b1},
    {1'b0,1'b1,1'b1,12'h004,32'h0,       32'h2,       1'b1},
    {1'b1,1'b1,1'b1,12'h004,32'h2,       32'h0,       1'b0},
    {1'b1,1'b0,1'b1,12'hC00,32'hDEADBEEF,32'h0,       1'b0},
    {1'b0,1'b1,1'b1,12'hC00,32'h0,       32'hDEADBEEF,1'b0},
    {1'b0,1'b1,1'b1,12'h408,32'h0,       32'h0,       1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd1);
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    access(1'b0, a, 32'h0);
    chk(req, rsp_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq", 32'(irq), 32'd0);
    chk("R11 core_rst", 32'(core_rst), 32'd0);
    chk("R11 mst_attr", 32'(mst_attr), 32'd0);
    chk("R11 req_ready", 32'(req_ready), 32'd1);
    rd("R11 INT_STAT", 12'h004, 32'h0);
    rd("R11 host reg", 12'h404, 32'h0);

    // R2 R3 R4 R5 R6 R7 R8 table walk
    for (int i = 0; i < NV; i++) begin
      role_host   = VEC[i][78];
      master_idle = VEC[i][77];
      access(VEC[i][79], VEC[i][76:65], VEC[i][64:33]);
      if (!VEC[i][79]) chk($sformatf("R2-R5/R7 rdata vec %0d", i), rsp_rdata, VEC[i][32:1]);
      chk($sformatf("R4/R6/R8 irq vec %0d", i), 32'(irq), 32'(VEC[i][0]));
    end
    master_idle = 1'b1;
    // R7 attribute port keeps the idle-time value
    chk("R7 mst_attr", 32'(mst_attr), 32'h5);

    // R9 soft reset pulse length and stall
    role_host = 1'b1;
    access(1'b1, 12'h000, 32'h1);
    cnt = 0;
    while (core_rst && cnt < 100) begin
      cnt++;
      chk("R9 req_ready low", 32'(req_ready), 32'd0);
      @(negedge clk);
    end
    chk("R9 pulse length", 32'(cnt), 32'd8);
    rd("R9 CTRL readback", 12'h000, 32'h0);
    // R10 what the pulse clears and keeps
    rd("R10 host cleared", 12'h400, 32'h0);
    rd("R10 power cleared", 12'hC00, 32'h0);
    rd("R10 INT_MASK kept", 12'h008, 32'h3);
    rd("R10 MST_ATTR kept", 12'h00C, 32'h5);
    role_host = 1'b0;
    rd("R10 device cleared", 12'h800, 32'h0);
    rd("R10 INT_STAT cleared", 12'h004, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule